// File: doc/BRIEF.md
# Two-Vector Delay Test Launcher with Scan Chain

This block wraps a combinational logic block under test with a row of launch flops on its inputs and a row of capture flops on its outputs. All of these flops are joined into one serial scan chain. Each scan cell picks its next value through a 2:1 multiplexer: with the scan enable high it takes the previous cell's output, and with it low it takes its functional input. A small sequencer uses the chain to apply two-vector delay tests. It serially loads the first vector and derives the second vector from it. One clock later it captures the response and then shifts the result out.

The second vector cannot be chosen freely. In shift-launch mode it is the first vector moved one position along the chain, produced by one extra shift clock. In functional-launch mode it is whatever the upstream logic (`up_func_i`) computes from the first vector, loaded by one functional clock. A static mode skips the launch step entirely and covers single-vector stuck-at style tests. While a result unloads, the next first vector can stream in through `scan_in_i`. A following start with `reuse_i` set then skips the load phase. Every captured response is also kept in a parallel readout register.

Sequencer states: IDLE, SHIFT_V1, LAUNCH, CAPTURE, SHIFT_OUT, DONE.

Transitions:
- IDLE to SHIFT_V1 on start with reuse low.
- IDLE to LAUNCH on start with reuse high in a launch mode.
- IDLE to CAPTURE on start with reuse high in static mode.
- SHIFT_V1 to LAUNCH after N shifts in a launch mode.
- SHIFT_V1 to CAPTURE after N shifts in static mode.
- LAUNCH to CAPTURE.
- CAPTURE to SHIFT_OUT.
- SHIFT_OUT to DONE after N shifts.
- DONE to IDLE.

Top module: `dvl_launcher`

## Requirements
- R1: Each scan cell loads its serial input when the scan enable is high and its functional input when it is low. A cell whose group is not enabled holds its value. Chain position 0 takes `scan_in_i`.
- R2: The chain has N = 2*W cells. Position i (i < W) is launch flop i and drives `cut_in_o[i]`. Position W+i is capture flop i and samples `cut_out_i[i]`. `scan_out_o` is position N-1. A start in IDLE with `reuse_i` low shifts for exactly N clocks, so the bit driven on the first shift ends in position N-1.
- R3: After the load, the first vector stays on `cut_in_o` until the launch edge.
- R4: In shift-launch mode (`mode_i` = 01), the launch clock is one more shift with `scan_en_o` high. The second vector becomes {V1[W-2:0], scan_in_i}.
- R5: In functional-launch mode (`mode_i` = 10), the launch clock has `scan_en_o` low and the launch flops load `up_func_i`.
- R6: The capture clock comes exactly one clock after the launch clock. The capture flops and the readout `resp_o` both load `cut_out_i`.
- R7: In static mode (`mode_i` = 00, and also 11), there is no launch step. The capture clock directly follows the last load shift, and the launch flops keep V1.
- R8: SHIFT_OUT shifts for N clocks. `scan_out_o` presents capture flop W-1 down to 0 first, then launch flop W-1 down to 0. `scan_in_i` is shifted in at the same time.
- R9: A start with `reuse_i` high skips SHIFT_V1 and tests the chain contents left by the previous unload.
- R10: `done_o` is high for exactly one clock after the last unload shift. `resp_o` holds its value until the next capture.
- R11: `start_i` is ignored outside IDLE.
- R12: After reset, all chain cells, `resp_o`, `done_o` and `scan_en_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start one test (sampled in IDLE) |
| reuse_i | input | 1 | Skip loading; use the chain contents already present |
| mode_i | input | 2 | 00/11 static, 01 shift-launch, 10 functional-launch |
| scan_in_i | input | 1 | Serial scan data in |
| scan_out_o | output | 1 | Serial scan data out (last chain cell) |
| scan_en_o | output | 1 | Current scan enable of the chain |
| done_o | output | 1 | One-clock end-of-test pulse |
| up_func_i | input | W | Upstream logic outputs, functional inputs of the launch flops |
| cut_in_o | output | W | Launch flop values driving the block under test |
| cut_out_i | input | W | Outputs of the block under test |
| resp_o | output | W | Parallel readout of the last captured response |

## Verification
The hardest situation to reach is the reuse path. A start with `reuse_i` high depends on what was shifted in during the previous unload. The bench therefore streams a known next vector on `scan_in_i` during every SHIFT_OUT and periodically starts the next test with reuse set. It predicts the launch vector from the bits it shifted. The bench also pulses `start_i` in the middle of loading and unloading, and then checks that `done_o` still lands on the exact cycle.

// File: rtl/dvl_pkg.sv
package dvl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SHIFT_V1,
        ST_LAUNCH,
        ST_CAPTURE,
        ST_SHIFT_OUT,
        ST_DONE
    } seq_state_e;

    localparam logic [1:0] TM_STATIC = 2'b00;
    localparam logic [1:0] TM_SHIFT  = 2'b01;
    localparam logic [1:0] TM_FUNC   = 2'b10;

    function automatic logic mode_is_static(input logic [1:0] m);
        return (m != TM_SHIFT) && (m != TM_FUNC);
    endfunction

endpackage

// File: rtl/dvl_scan_cell.sv
module dvl_scan_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic se_i,
    input  logic en_i,
    input  logic si_i,
    input  logic d_i,
    output logic q_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q_o <= 1'b0;
        else if (en_i)
            q_o <= se_i ? si_i : d_i;
    end

    // R1: serial path, functional path, hold
    p_serial_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && se_i) |=> (q_o == $past(si_i)));
    p_func_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !se_i) |=> (q_o == $past(d_i)));
    p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> $stable(q_o));

endmodule

// File: rtl/dvl_scan_chain.sv
module dvl_scan_chain #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         se_i,
    input  logic         en_launch_i,
    input  logic         en_cap_i,
    input  logic         scan_in_i,
    input  logic [W-1:0] up_func_i,
    input  logic [W-1:0] cut_out_i,
    output logic [W-1:0] cut_in_o,
    output logic         scan_out_o
);

    localparam int N = 2 * W;

    logic [N-1:0] cell_q;

    for (genvar k = 0; k < N; k++) begin : g_cell
        logic ser_in;
        logic fun_in;
        logic grp_en;
        if (k == 0) begin : g_head
            assign ser_in = scan_in_i;
        end else begin : g_body
            assign ser_in = cell_q[k-1];
        end
        if (k < W) begin : g_launch
            assign fun_in = up_func_i[k];
            assign grp_en = en_launch_i;
        end else begin : g_capture
            assign fun_in = cut_out_i[k-W];
            assign grp_en = en_cap_i;
        end
        dvl_scan_cell u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .se_i  (se_i),
            .en_i  (grp_en),
            .si_i  (ser_in),
            .d_i   (fun_in),
            .q_o   (cell_q[k])
        );
    end

    assign cut_in_o   = cell_q[W-1:0];
    assign scan_out_o = cell_q[N-1];

endmodule

// File: rtl/dvl_sequencer.sv
module dvl_sequencer
    import dvl_pkg::*;
#(
    parameter int N = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       reuse_i,
    input  logic [1:0] mode_i,
    output logic       se_o,
    output logic       en_launch_o,
    output logic       en_cap_o,
    output logic       rd_load_o,
    output logic       done_o
);

    localparam int CW = (N > 2) ? $clog2(N) : 1;

    seq_state_e     state_q, state_d;
    logic [CW-1:0]  cnt_q;
    logic [1:0]     mode_q;
    logic           last_shift;

    assign last_shift = (cnt_q == CW'(N - 1));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    if (!reuse_i)                    state_d = ST_SHIFT_V1;
                    else if (mode_is_static(mode_i)) state_d = ST_CAPTURE;
                    else                             state_d = ST_LAUNCH;
                end
            end
            ST_SHIFT_V1: begin
                if (last_shift)
                    state_d = mode_is_static(mode_q) ? ST_CAPTURE : ST_LAUNCH;
            end
            ST_LAUNCH:    state_d = ST_CAPTURE;
            ST_CAPTURE:   state_d = ST_SHIFT_OUT;
            ST_SHIFT_OUT: if (last_shift) state_d = ST_DONE;
            ST_DONE:      state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            mode_q  <= TM_STATIC;
        end else begin
            state_q <= state_d;
            if (state_d != state_q)
                cnt_q <= '0;
            else if (state_q == ST_SHIFT_V1 || state_q == ST_SHIFT_OUT)
                cnt_q <= cnt_q + 1'b1;
            if (state_q == ST_IDLE && start_i)
                mode_q <= mode_i;
        end
    end

    always_comb begin
        se_o        = 1'b0;
        en_launch_o = 1'b0;
        en_cap_o    = 1'b0;
        rd_load_o   = 1'b0;
        done_o      = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_SHIFT_V1, ST_SHIFT_OUT: begin
                se_o        = 1'b1;
                en_launch_o = 1'b1;
                en_cap_o    = 1'b1;
            end
            ST_LAUNCH: begin
                se_o        = (mode_q == TM_SHIFT);
                en_launch_o = 1'b1;
                en_cap_o    = (mode_q == TM_SHIFT);
            end
            ST_CAPTURE: begin
                en_cap_o  = 1'b1;
                rd_load_o = 1'b1;
            end
            ST_DONE: done_o = 1'b1;
            default: ;
        endcase
    end

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    p_done_to_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE) |=> (state_q == ST_IDLE));
    p_launch_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LAUNCH) |=> (state_q == ST_CAPTURE));
    p_capture_unload_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CAPTURE) |=> (state_q == ST_SHIFT_OUT));
    p_static_skip_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHIFT_V1 && last_shift && mode_is_static(mode_q))
        |=> (state_q == ST_CAPTURE));
    p_shift_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHIFT_V1 || state_q == ST_SHIFT_OUT) |-> (int'(cnt_q) < N));
    p_reuse_skip_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start_i && reuse_i) |=> (state_q != ST_SHIFT_V1));

endmodule

// File: rtl/dvl_launcher.sv
module dvl_launcher #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic         reuse_i,
    input  logic [1:0]   mode_i,
    input  logic         scan_in_i,
    output logic         scan_out_o,
    output logic         scan_en_o,
    output logic         done_o,
    input  logic [W-1:0] up_func_i,
    output logic [W-1:0] cut_in_o,
    input  logic [W-1:0] cut_out_i,
    output logic [W-1:0] resp_o
);

    localparam int N = 2 * W;

    logic se, en_launch, en_cap, rd_load;

    dvl_sequencer #(.N(N)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .reuse_i     (reuse_i),
        .mode_i      (mode_i),
        .se_o        (se),
        .en_launch_o (en_launch),
        .en_cap_o    (en_cap),
        .rd_load_o   (rd_load),
        .done_o      (done_o)
    );

    dvl_scan_chain #(.W(W)) u_chain (
        .clk         (clk),
        .rst_n       (rst_n),
        .se_i        (se),
        .en_launch_i (en_launch),
        .en_cap_i    (en_cap),
        .scan_in_i   (scan_in_i),
        .up_func_i   (up_func_i),
        .cut_out_i   (cut_out_i),
        .cut_in_o    (cut_in_o),
        .scan_out_o  (scan_out_o)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            resp_o <= '0;
        else if (rd_load)
            resp_o <= cut_out_i;
    end

    assign scan_en_o = se;

    p_resp_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_load |=> (resp_o == $past(cut_out_i)));
    p_resp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_load |=> $stable(resp_o));

endmodule

// File: tb/dvl_launcher_tb_top.sv
module dvl_launcher_tb_top;

    localparam int W = 4;
    localparam int N = 2 * W;
    localparam logic [W-1:0] UPAT = {(W/2){2'b01}};
    localparam logic [W-1:0] BPAT = {(W/2){2'b10}};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, reuse = 1'b0, scan_in = 1'b0;
    logic [1:0] mode = 2'b00;
    logic scan_out, scan_en, done;
    logic [W-1:0] up_func, cut_in, cut_out, resp;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    logic [N-1:0] stored = '0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cycles++;

    function automatic logic [W-1:0] f_up(input logic [W-1:0] x);
        return {x[0], x[W-1:1]} ^ UPAT;
    endfunction
    function automatic logic [W-1:0] f_blk(input logic [W-1:0] x);
        return x ^ {x[W-2:0], x[W-1]} ^ BPAT;
    endfunction

    assign up_func = f_up(cut_in);
    assign cut_out = f_blk(cut_in);

    dvl_launcher #(.W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start), .reuse_i(reuse),
        .mode_i(mode), .scan_in_i(scan_in), .scan_out_o(scan_out),
        .scan_en_o(scan_en), .done_o(done), .up_func_i(up_func),
        .cut_in_o(cut_in), .cut_out_i(cut_out), .resp_o(resp)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_test(input logic [1:0] m, input logic ru,
                            input logic [N-1:0] v1chain, input logic [N-1:0] nxt,
                            input logic los_si);
        logic [N-1:0] cur;
        logic [W-1:0] v2, cap;
        logic [N-1:0] expc;
        bit stat;
        stat = (m == 2'b00) || (m == 2'b11);
        @(negedge clk);
        mode = m; reuse = ru; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (!ru) begin
            for (int t = 0; t < N; t++) begin
                scan_in = v1chain[N-1-t];
                start = (t == 2);           // R11: ignored while loading
                @(negedge clk);
            end
            start = 1'b0;
            cur = v1chain;
        end else begin
            cur = stored;                   // R9: reuse contents
        end
        chk(cut_in == cur[W-1:0], ru ? "R9 reuse vector" : "R3 V1 applied",
            int'(cut_in), int'(cur[W-1:0]));
        if (!stat) begin
            chk(scan_en == (m == 2'b01), m == 2'b01 ? "R4 launch se" : "R5 launch se",
                int'(scan_en), int'(m == 2'b01));
            scan_in = los_si;
            @(negedge clk);
            if (m == 2'b01) v2 = {cur[W-2:0], los_si};
            else            v2 = f_up(cur[W-1:0]);
            chk(cut_in == v2, m == 2'b01 ? "R4 shift vector" : "R5 func vector",
                int'(cut_in), int'(v2));
        end else begin
            v2 = cur[W-1:0];
            chk(scan_en == 1'b0, "R7 capture follows load", int'(scan_en), 0);
        end
        @(negedge clk);
        cap = f_blk(v2);
        chk(resp == cap, "R6 captured response", int'(resp), int'(cap));
        chk(cut_in == v2, "R7 launch flops after capture", int'(cut_in), int'(v2));
        expc = {cap, v2};
        for (int t = 0; t < N; t++) begin
            chk(scan_out == expc[N-1-t], "R8 unload bit", int'(scan_out), int'(expc[N-1-t]));
            chk(done == 1'b0, "R10 no early done", int'(done), 0);
            scan_in = nxt[N-1-t];
            start = (t == 1);               // R11: ignored while unloading
            @(negedge clk);
        end
        start = 1'b0;
        chk(done == 1'b1, "R10 done pulse", int'(done), 1);
        chk(resp == cap, "R10 readout held", int'(resp), int'(cap));
        stored = nxt;
        @(negedge clk);
        chk(done == 1'b0, "R10 done one cycle", int'(done), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R12: reset state
        chk(scan_out == 1'b0 && cut_in == '0, "R12 chain reset", int'(cut_in), 0);
        chk(resp == '0, "R12 readout reset", int'(resp), 0);
        chk(done == 1'b0 && scan_en == 1'b0, "R12 control reset", int'({done, scan_en}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(done == 1'b0, "R11 idle without start", int'(done), 0);
        for (int mi = 0; mi < 4; mi++) begin
            for (int v = 0; v < (1 << W); v++) begin
                logic [W-1:0] lv;
                logic [N-1:0] full, nxt;
                lv   = W'(v);
                full = {lv ^ W'(9), lv};
                nxt  = {~lv, lv + W'(1)};
                run_test(2'(mi), (v % 4) == 3, full, nxt, ~lv[0]);
            end
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        wait (cycles > 20000);
        bad++;
        total++;
        $display("FAIL watchdog R10 actual=%0d expected=done", cycles);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule